// File: doc/BRIEF.md
# Configurable Multi-Input Strength Gate

This block is a three-valued logic gate with a parameterised number of inputs (two or more). Each input carries a 2-bit value that is logic 0, logic 1 or unknown. A select input picks AND, OR or XOR as the function. A count input inverts a number of inputs before the function is applied. The block drives a true output and, as a build option, a complementary output. Each output is a value paired with a separate drive-strength code.

In normal mode the outputs carry the logic result at strong strength. In open-collector mode the output value is held at logic 0, and the result is carried in the strength code instead. An external pull-up can then produce the high level. An optional output register, chosen by parameter and present by default, captures value and strength on the rising clock edge. It has a synchronous active-low reset.

Top module: `mvg_gate`

## Requirements
- R1: Function select codes are 00 AND, 01 OR and 10 XOR. Code 11 behaves as AND.
- R2: AND yields 0 when any effective input is 0. Otherwise it yields unknown when any effective input is unknown. Otherwise it yields 1.
- R3: OR yields 1 when any effective input is 1. Otherwise it yields unknown when any effective input is unknown. Otherwise it yields 0.
- R4: XOR yields unknown when any effective input is unknown. Otherwise it yields odd parity of the effective inputs.
- R5: A count k on `inv_cnt` inverts inputs 0 to k-1 before evaluation. Inversion swaps 0 and 1 and leaves unknown as unknown.
- R6: In open-collector mode (`oc_mode`=1) every output value is 0. A result of 1 gives strength 01 (high-impedance), a result of 0 gives 00 (strong), and an unknown result gives 10 (undetermined).
- R7: In normal mode every output reports strength 00 (strong), and the true output value equals the result.
- R8: The complementary output is the result with 0 and 1 swapped and unknown kept as unknown. It obeys the same strength rules as the true output.
- R9: With the register present, outputs follow the inputs one rising edge later. While `rst_n` is low at an edge, both outputs load value 00 with strength 01, whatever the inputs are.
- R10: Value codes are 00 for logic 0, 01 for logic 1 and 10 for unknown. The input code 11 is treated as unknown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vals | input | 2*NUM_IN | Packed input values; input i occupies bits [2i+1:2i] |
| fn_sel | input | 2 | Function select |
| inv_cnt | input | $clog2(NUM_IN+1) | Number of lowest-indexed inputs to invert |
| oc_mode | input | 1 | Open-collector mode enable |
| out_val | output | 2 | True output value |
| out_str | output | 2 | True output strength |
| outn_val | output | 2 | Complementary output value |
| outn_str | output | 2 | Complementary output strength |

## Verification
Two things can land in the same cycle: input inversion and unknown dominance. An inverted input can turn into the controlling value, or an unknown can pass through inversion while another input controls the result. The sweep covers every three-input pattern under every inversion count, every function and both output modes, so these overlaps are all exercised. Each registered result is compared one edge later with a value the bench computes arithmetically. Reset is also asserted while the inputs would produce a strong 1, and the reset value must win.

// File: rtl/mvg_pkg.sv
// Package: shared value/strength codes and function-select encoding for the
// multi-input strength gate. Assumes 2-bit codes throughout.
package mvg_pkg;

    typedef logic [1:0] lv_t;
    typedef logic [1:0] ds_t;

    localparam lv_t LV_0 = 2'b00;
    localparam lv_t LV_1 = 2'b01;
    localparam lv_t LV_X = 2'b10;

    localparam ds_t DS_STRONG = 2'b00;
    localparam ds_t DS_HIZ    = 2'b01;
    localparam ds_t DS_UNDET  = 2'b10;

    typedef enum logic [1:0] {
        FN_AND = 2'b00,
        FN_OR  = 2'b01,
        FN_XOR = 2'b10,
        FN_RSV = 2'b11
    } fn_e;

    // Map any code with the upper bit set to unknown.
    function automatic lv_t lv_norm(lv_t v);
        return v[1] ? LV_X : v;
    endfunction

    // Three-valued inversion: 0<->1, unknown stays unknown.
    function automatic lv_t lv_not(lv_t v);
        lv_t n;
        n = lv_norm(v);
        if (n == LV_X) return LV_X;
        return (n == LV_0) ? LV_1 : LV_0;
    endfunction

endpackage

// File: rtl/mvg_invert.sv
// Module: input conditioning stage. Normalises every input code and inverts
// the lowest-indexed inputs whose index is below inv_cnt.
// Assumes: CW is wide enough to hold NUM_IN.
module mvg_invert
    import mvg_pkg::*;
#(
    parameter int NUM_IN = 3,
    parameter int CW     = $clog2(NUM_IN + 1)
) (
    input  logic [2*NUM_IN-1:0] raw_vals,
    input  logic [CW-1:0]       inv_cnt,
    output logic [2*NUM_IN-1:0] eff_vals
);

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        // Per-input: invert when the index falls below the count.
        assign eff_vals[2*gi +: 2] = (inv_cnt > CW'(gi)) ? lv_not(raw_vals[2*gi +: 2])
                                                         : lv_norm(raw_vals[2*gi +: 2]);
    end

endmodule

// File: rtl/mvg_reduce.sv
// Module: three-valued reduction of all effective inputs by AND, OR or XOR.
// Assumes: inputs are already normalised (no code 11).
module mvg_reduce
    import mvg_pkg::*;
#(
    parameter int NUM_IN = 3
) (
    input  logic [2*NUM_IN-1:0] eff_vals,
    input  fn_e                 fn_sel,
    output lv_t                 result
);

    logic any0, any1, anyx, parity;

    // Scan inputs for dominant values, unknowns and odd parity.
    always_comb begin
        any0   = 1'b0;
        any1   = 1'b0;
        anyx   = 1'b0;
        parity = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (eff_vals[2*i +: 2] == LV_0) any0 = 1'b1;
            if (eff_vals[2*i +: 2] == LV_1) begin
                any1   = 1'b1;
                parity = ~parity;
            end
            if (eff_vals[2*i +: 2] == LV_X) anyx = 1'b1;
        end
    end

    // Apply the selected function with dominance rules.
    always_comb begin
        unique case (fn_sel)
            FN_OR:   result = any1 ? LV_1 : (anyx ? LV_X : LV_0);
            FN_XOR:  result = anyx ? LV_X : (parity ? LV_1 : LV_0);
            default: result = any0 ? LV_0 : (anyx ? LV_X : LV_1);
        endcase
    end

    // Guard: an AND result of 1 needs every input to be a clean 1 (R2).
    always_comb begin
        if ((fn_sel == FN_AND || fn_sel == FN_RSV) && result == LV_1) begin
            p_and_all_ones_r2: assert (eff_vals == {NUM_IN{LV_1}});
        end
    end

    // Guard: XOR never yields a clean value while an input is unknown (R4).
    always_comb begin
        if (fn_sel == FN_XOR && eff_vals[2*0 +: 2] == LV_X) begin
            p_xor_unknown_r4: assert (result == LV_X);
        end
    end

endmodule

// File: rtl/mvg_drive.sv
// Module: output driver mapping a logic result to value/strength pairs for the
// true and optional complementary outputs, in normal or open-collector mode.
// Assumes: result is a normalised code.
module mvg_drive
    import mvg_pkg::*;
#(
    parameter bit COMP_EN = 1'b1
) (
    input  lv_t  result,
    input  logic oc_mode,
    output lv_t  t_val,
    output ds_t  t_str,
    output lv_t  c_val,
    output ds_t  c_str
);

    lv_t comp_res;

    // Strength carried by a result under open-collector drive.
    function automatic ds_t oc_strength(lv_t r);
        if (r == LV_1) return DS_HIZ;
        if (r == LV_0) return DS_STRONG;
        return DS_UNDET;
    endfunction

    assign comp_res = lv_not(result);

    // True output mapping.
    always_comb begin
        t_val = oc_mode ? LV_0 : result;
        t_str = oc_mode ? oc_strength(result) : DS_STRONG;
    end

    if (COMP_EN) begin : g_comp
        // Complementary output mapping.
        always_comb begin
            c_val = oc_mode ? LV_0 : comp_res;
            c_str = oc_mode ? oc_strength(comp_res) : DS_STRONG;
        end
    end else begin : g_nocomp
        // Unused complement parks at released low.
        always_comb begin
            c_val = LV_0;
            c_str = DS_HIZ;
        end
    end

    // Guard: open-collector never drives a high value (R6).
    always_comb begin
        if (oc_mode) begin
            p_oc_value_low_r6: assert (t_val == LV_0 && c_val == LV_0);
        end
    end

    // Guard: true and complement never both release in open-collector mode (R8).
    always_comb begin
        if (oc_mode && COMP_EN) begin
            p_comp_not_both_hiz_r8: assert (!(t_str == DS_HIZ && c_str == DS_HIZ));
        end
    end

endmodule

// File: rtl/mvg_gate.sv
// Module: top of the configurable multi-input strength gate. Chains input
// conditioning, reduction and output drive, with an optional output register.
// Assumes: NUM_IN >= 2; synchronous active-low reset.
module mvg_gate
    import mvg_pkg::*;
#(
    parameter int NUM_IN  = 3,
    parameter bit COMP_EN = 1'b1,
    parameter bit REG_OUT = 1'b1,
    localparam int CW     = $clog2(NUM_IN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*NUM_IN-1:0] in_vals,
    input  logic [1:0]          fn_sel,
    input  logic [CW-1:0]       inv_cnt,
    input  logic                oc_mode,
    output logic [1:0]          out_val,
    output logic [1:0]          out_str,
    output logic [1:0]          outn_val,
    output logic [1:0]          outn_str
);

    logic [2*NUM_IN-1:0] eff_vals;
    lv_t result;
    lv_t t_val, c_val;
    ds_t t_str, c_str;

    mvg_invert #(.NUM_IN(NUM_IN), .CW(CW)) i_invert (
        .raw_vals (in_vals),
        .inv_cnt  (inv_cnt),
        .eff_vals (eff_vals)
    );

    mvg_reduce #(.NUM_IN(NUM_IN)) i_reduce (
        .eff_vals (eff_vals),
        .fn_sel   (fn_e'(fn_sel)),
        .result   (result)
    );

    mvg_drive #(.COMP_EN(COMP_EN)) i_drive (
        .result  (result),
        .oc_mode (oc_mode),
        .t_val   (t_val),
        .t_str   (t_str),
        .c_val   (c_val),
        .c_str   (c_str)
    );

    if (REG_OUT) begin : g_reg
        // Capture value and strength; reset loads released logic 0.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_val  <= LV_0;
                out_str  <= DS_HIZ;
                outn_val <= LV_0;
                outn_str <= DS_HIZ;
            end else begin
                out_val  <= t_val;
                out_str  <= t_str;
                outn_val <= c_val;
                outn_str <= c_str;
            end
        end

        // Reset state is visible on the first edge after release (R9).
        p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (out_val == LV_0 && out_str == DS_HIZ));

        // Normal mode drives strong one edge later (R7).
        p_normal_strong_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !oc_mode |=> (out_str == DS_STRONG));

        // Open-collector mode holds value low one edge later (R6).
        p_oc_low_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
            oc_mode |=> (out_val == LV_0));
    end else begin : g_comb
        // Pass-through when no output stage is wanted.
        always_comb begin
            out_val  = t_val;
            out_str  = t_str;
            outn_val = c_val;
            outn_str = c_str;
        end
    end

endmodule

// File: tb/test_mvg_gate.sv
module test_mvg_gate;

    localparam int N  = 3;
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2*N-1:0] in_vals = '0;
    logic [1:0]    fn_sel = 2'b00;
    logic [CW-1:0] inv_cnt = '0;
    logic          oc_mode = 1'b0;
    logic [1:0]    out_val, out_str, outn_val, outn_str;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mvg_gate #(.NUM_IN(N)) i_mvg_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vals  (in_vals),
        .fn_sel   (fn_sel),
        .inv_cnt  (inv_cnt),
        .oc_mode  (oc_mode),
        .out_val  (out_val),
        .out_str  (out_str),
        .outn_val (outn_val),
        .outn_str (outn_str)
    );

    task automatic check4(string tag, int ev, int es, int cv, int cs);
        checks++;
        if (out_val != 2'(ev) || out_str != 2'(es) || outn_val != 2'(cv) || outn_str != 2'(cs)) begin
            fails++;
            $display("FAIL %s: got val=%0d str=%0d nval=%0d nstr=%0d expected val=%0d str=%0d nval=%0d nstr=%0d",
                     tag, out_val, out_str, outn_val, outn_str, ev, es, cv, cs);
        end
    endtask

    // Expected outputs computed arithmetically from the requirements.
    task automatic expect_for(int vals[N], int fn, int k, bit oc, string tag);
        int c0 = 0, c1 = 0, cx = 0, r, cr, es, cs, ev, cv;
        for (int i = 0; i < N; i++) begin
            int v = (vals[i] >= 2) ? 2 : vals[i];     // R10 normalise
            if (i < k && v != 2) v = 1 - v;           // R5 inversion
            if (v == 0) c0++;
            else if (v == 1) c1++;
            else cx++;
        end
        if (fn == 1)      r = (c1 > 0) ? 1 : (cx > 0 ? 2 : 0);   // R3
        else if (fn == 2) r = (cx > 0) ? 2 : (c1 % 2);           // R4
        else              r = (c0 > 0) ? 0 : (cx > 0 ? 2 : 1);   // R2, R1
        cr = (r == 2) ? 2 : 1 - r;                               // R8
        if (oc) begin                                            // R6
            ev = 0; cv = 0;
            es = (r == 1) ? 1 : (r == 0 ? 0 : 2);
            cs = (cr == 1) ? 1 : (cr == 0 ? 0 : 2);
        end else begin                                           // R7
            ev = r; cv = cr; es = 0; cs = 0;
        end
        check4(tag, ev, es, cv, cs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int vals[N];
        string tag;
        // R9: reset state while inputs would give a strong 1 under OR.
        in_vals = {N{2'b01}};
        fn_sel  = 2'b01;
        @(negedge clk);
        @(negedge clk);
        check4("R9 reset", 0, 1, 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check4("R3 after release", 1, 0, 0, 0);

        // Exhaustive sweep over mode, function, inversion count and inputs.
        for (int oc = 0; oc < 2; oc++) begin
            for (int fn = 0; fn < 4; fn++) begin
                for (int k = 0; k <= N; k++) begin
                    for (int code = 0; code < 27; code++) begin
                        int c = code;
                        for (int i = 0; i < N; i++) begin
                            vals[i] = c % 3;
                            c = c / 3;
                        end
                        in_vals = {2'(vals[2]), 2'(vals[1]), 2'(vals[0])};
                        fn_sel  = 2'(fn);
                        inv_cnt = CW'(k);
                        oc_mode = oc[0];
                        @(negedge clk);
                        if (oc == 1)      tag = "R6";
                        else if (fn == 3) tag = "R1";
                        else if (k > 0)   tag = "R5";
                        else if (fn == 0) tag = "R2";
                        else if (fn == 1) tag = "R3";
                        else              tag = "R4";
                        expect_for(vals, fn, k, oc[0], tag);
                    end
                end
            end
        end

        // R10: code 11 on an input acts as unknown.
        vals = '{3, 1, 1};
        in_vals = {2'b01, 2'b01, 2'b11};
        fn_sel = 2'b00; inv_cnt = '0; oc_mode = 1'b0;
        @(negedge clk);
        expect_for(vals, 0, 0, 1'b0, "R10 and");
        inv_cnt = CW'(1);
        fn_sel  = 2'b10;
        @(negedge clk);
        expect_for(vals, 2, 1, 1'b0, "R10 xor inverted");

        // R9: reset reasserted mid-run dominates an input giving strong 1.
        in_vals = {N{2'b01}}; fn_sel = 2'b00; inv_cnt = '0;
        @(negedge clk);
        check4("R7 strong one", 1, 0, 0, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check4("R9 reset wins", 0, 1, 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check4("R8 after reset", 1, 0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule